// File: doc/BRIEF.md
# Debug Instruction Injection Controller

This block sits on the debug side of a processor core. It lets an external debugger push 32-bit instruction words into a halted core, one word at a time. It also holds three cache policy overrides that restrict the L1 caches while the core is halted.

The debugger reaches the block through a small register bus. Writes take effect on the clock edge, and reads are combinational on the address. There are four word addresses:

| Address | Register |
|---------|----------|
| 0 | Status / control |
| 1 | Transfer register (write-only) |
| 2 | Cache override |
| 3 | Unused |

The core supplies two signals:
- a halted (debug-state) level;
- a single-cycle completion acknowledge, once it has finished an injected instruction.

The issue path is a three-state machine:
- **READY**: the completion flag reads 1 and a transfer write may be accepted.
- **ISSUE**: the one cycle on which the instruction-valid pulse is driven.
- **WAIT**: waiting for the core's acknowledge.

The transitions are:
- READY→ISSUE on an accepted transfer write.
- ISSUE→WAIT unconditionally.
- WAIT→READY on the acknowledge.

Top module: `dbgi_ctrl`

## Requirements
- R1: After reset, the following hold:
  - status reads exactly 0x0200_0000 (completion flag set, execute enable clear, overrun clear);
  - the cache override register reads 0;
  - `instr_valid_o` is low.
- R2: A read of address 1 (transfer register) or address 3 returns zero.
- R3: A write to address 1 is accepted only when all three of these hold in the write cycle:
  - `core_halted_i` is high;
  - the execute-enable bit (status bit 13, written through address 0) is 1;
  - the completion flag is 1.
  
  If `core_halted_i` is low or execute enable is 0, the write produces no pulse and sets no flag.
- R4: An accepted write produces `instr_valid_o` high for exactly one cycle, the cycle after the write. On that cycle `instr_data_o` equals the written word.
- R5: The completion flag (status bit 25, read-only) reads 0 from the pulse cycle onwards. It reads 1 again on the cycle after a `core_done_i` pulse seen in WAIT. An acknowledge during the pulse cycle, or while the flag is already 1, is ignored.
- R6: A write to address 1 while the completion flag is 0 is dropped, and it sets the sticky overrun flag (status bit 6). Writing address 0 with bit 6 = 1 clears the overrun flag; writing bit 6 = 0 leaves it unchanged.
- R7: The cache override register (address 2) holds bits [2:0] as written. Bits [31:3] always read zero.
- R8: While `core_halted_i` is high, the three cache policy outputs follow the register:
  - `wt_normal_o` equals bit 2;
  - `ifill_normal_o` equals bit 1;
  - `dfill_normal_o` equals bit 0.
  
  A 0 on an output selects the restrictive policy: forced write-through, or line-fills disabled.
- R9: While `core_halted_i` is low, all three cache policy outputs are 1, whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| core_halted_i | input | 1 | Core is in debug state |
| core_done_i | input | 1 | Core finished the injected instruction (pulse) |
| instr_valid_o | output | 1 | Injected instruction valid (single-cycle pulse) |
| instr_data_o | output | 32 | Injected instruction word |
| wt_normal_o | output | 1 | 0 forces write-through on write-back regions |
| ifill_normal_o | output | 1 | 0 disables instruction cache line-fills |
| dfill_normal_o | output | 1 | 0 disables data cache line-fills |

## Verification
The bench builds the block with its default parameters:
- a 32-bit data word;
- execute enable at bit 13, completion at bit 25 and overrun at bit 6;
- three cache policy bits.

These values place the status fields where the debugger expects them. They also let a single 32-bit write carry reserved ones above bit 2 of the cache register.

A directed phase walks every FSM transition and each gating condition: not halted, not enabled, and an acknowledge during the pulse cycle. A long randomized phase then mixes halt changes, overlapping writes and stray acknowledges. The randomized phase drives the overrun and clear paths many times against the behavioural model.

// File: rtl/dbgi_pkg.sv
package dbgi_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } inj_state_t;

    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_STAT  = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_XFER  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CACHE = 2'd2;

endpackage

// File: rtl/dbgi_issue_fsm.sv
module dbgi_issue_fsm
    import dbgi_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_wr,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic              core_halted,
    input  logic              exec_en,
    input  logic              core_done,
    input  logic              ovr_clr,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_data,
    output logic              done_flag,
    output logic              overrun
);

    inj_state_t st_q, st_nxt;
    logic       accept;
    logic       drop;

    assign accept = xfer_wr && (st_q == ST_READY) && core_halted && exec_en;
    assign drop   = xfer_wr && (st_q != ST_READY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_READY;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_READY: if (accept) st_nxt = ST_ISSUE;
            ST_ISSUE: st_nxt = ST_WAIT;
            ST_WAIT:  if (core_done) st_nxt = ST_READY;
            default:  st_nxt = ST_READY;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        instr_valid = 1'b0;
        done_flag   = 1'b0;
        unique case (st_q)
            ST_READY: done_flag   = 1'b1;
            ST_ISSUE: instr_valid = 1'b1;
            ST_WAIT:  ;
            default:  ;
        endcase
    end

    // Instruction holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_data <= '0;
        end else if (accept) begin
            instr_data <= xfer_wdata;
        end
    end

    // Sticky overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);

    // R3
    issue_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> $past(xfer_wr && core_halted && exec_en));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_flag && !core_done) |=> !done_flag);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

endmodule

// File: rtl/dbgi_cache_ovr.sv
module dbgi_cache_ovr #(
    parameter int unsigned NBITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [NBITS-1:0] wdata,
    input  logic             core_halted,
    output logic [NBITS-1:0] policy_q,
    output logic [NBITS-1:0] policy_o
);

    // Override bits reset to the restrictive value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            policy_q <= '0;
        end else if (wr) begin
            policy_q <= wdata;
        end
    end

    // Per-bit gating by debug state
    for (genvar g = 0; g < NBITS; g++) begin : g_gate
        assign policy_o[g] = core_halted ? policy_q[g] : 1'b1;
    end

    // R9
    idle_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_halted |-> (policy_o == {NBITS{1'b1}}));

endmodule

// File: rtl/dbgi_ctrl.sv
module dbgi_ctrl
    import dbgi_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned EXEC_EN_BIT = 13,
    parameter int unsigned DONE_BIT    = 25,
    parameter int unsigned OVR_BIT     = 6,
    parameter int unsigned CACHE_BITS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              core_halted_i,
    input  logic              core_done_i,
    output logic              instr_valid_o,
    output logic [DATA_W-1:0] instr_data_o,
    output logic              wt_normal_o,
    output logic              ifill_normal_o,
    output logic              dfill_normal_o
);

    localparam int unsigned WT_IDX = CACHE_BITS - 1;

    logic                  wr_stat, wr_xfer, wr_cache;
    logic                  exec_en_q;
    logic                  done_flag, overrun;
    logic [CACHE_BITS-1:0] policy_q, policy_o;

    assign wr_stat  = reg_wr_i && (reg_addr_i == ADDR_STAT);
    assign wr_xfer  = reg_wr_i && (reg_addr_i == ADDR_XFER);
    assign wr_cache = reg_wr_i && (reg_addr_i == ADDR_CACHE);

    // Execute-enable control bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_en_q <= 1'b0;
        end else if (wr_stat) begin
            exec_en_q <= reg_wdata_i[EXEC_EN_BIT];
        end
    end

    dbgi_issue_fsm #(.DATA_W(DATA_W)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_wr     (wr_xfer),
        .xfer_wdata  (reg_wdata_i),
        .core_halted (core_halted_i),
        .exec_en     (exec_en_q),
        .core_done   (core_done_i),
        .ovr_clr     (wr_stat && reg_wdata_i[OVR_BIT]),
        .instr_valid (instr_valid_o),
        .instr_data  (instr_data_o),
        .done_flag   (done_flag),
        .overrun     (overrun)
    );

    dbgi_cache_ovr #(.NBITS(CACHE_BITS)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_cache),
        .wdata       (reg_wdata_i[CACHE_BITS-1:0]),
        .core_halted (core_halted_i),
        .policy_q    (policy_q),
        .policy_o    (policy_o)
    );

    assign wt_normal_o    = policy_o[WT_IDX];
    assign ifill_normal_o = policy_o[1];
    assign dfill_normal_o = policy_o[0];

    // Read multiplexer; write-only and unused addresses return zero
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_STAT: begin
                reg_rdata_o[EXEC_EN_BIT] = exec_en_q;
                reg_rdata_o[DONE_BIT]    = done_flag;
                reg_rdata_o[OVR_BIT]     = overrun;
            end
            ADDR_CACHE: reg_rdata_o[CACHE_BITS-1:0] = policy_q;
            default: ;
        endcase
    end

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_CACHE) |-> (reg_rdata_o[DATA_W-1:CACHE_BITS] == '0));

    // R2
    xfer_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_XFER) |-> (reg_rdata_o == '0));

endmodule

// File: tb/tb_dbgi_ctrl.sv
module tb_dbgi_ctrl;
    import dbgi_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        halted = 1'b0;
    logic        done_ack = 1'b0;
    logic        instr_valid;
    logic [31:0] instr_data;
    logic        wt_n, if_n, df_n;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgi_ctrl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .core_halted_i  (halted),
        .core_done_i    (done_ack),
        .instr_valid_o  (instr_valid),
        .instr_data_o   (instr_data),
        .wt_normal_o    (wt_n),
        .ifill_normal_o (if_n),
        .dfill_normal_o (df_n)
    );

    // Behavioural reference model
    bit          m_en, m_done, m_ovr, m_pulse;
    logic [31:0] m_instr;
    logic [2:0]  m_cache;

    initial begin
        m_en = 0; m_done = 1; m_ovr = 0; m_pulse = 0; m_instr = '0; m_cache = '0;
    end

    always @(posedge clk) begin
        bit nd, np, no, ne;
        if (!rst_n) begin
            m_en = 0; m_done = 1; m_ovr = 0; m_pulse = 0; m_cache = '0;
        end else begin
            nd = m_done; np = 0; no = m_ovr; ne = m_en;
            if (reg_wr && reg_addr == 2'd1) begin
                if (!m_done) no = 1;
                else if (halted && m_en) begin
                    m_instr = reg_wdata; np = 1; nd = 0;
                end
            end
            if (reg_wr && reg_addr == 2'd0) begin
                ne = reg_wdata[13];
                if (reg_wdata[6]) no = 0;
            end
            if (reg_wr && reg_addr == 2'd2) m_cache = reg_wdata[2:0];
            if (done_ack && !m_done && !m_pulse) nd = 1;
            m_done = nd; m_pulse = np; m_ovr = no; m_en = ne;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] v = '0;
        if (a == 2'd0) begin
            v[13] = m_en; v[25] = m_done; v[6] = m_ovr;
        end else if (a == 2'd2) begin
            v[2:0] = m_cache;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 valid", {31'd0, instr_valid}, {31'd0, m_pulse});
        if (m_pulse) chk("R4 data", instr_data, m_instr);
        if (halted) chk("R8 policy", {29'd0, wt_n, if_n, df_n}, {29'd0, m_cache});
        else        chk("R9 policy", {29'd0, wt_n, if_n, df_n}, 32'd7);
        case (reg_addr)
            2'd0:    chk("R5 status read", reg_rdata, exp_rd(reg_addr));
            2'd2:    chk("R7 cache read", reg_rdata, exp_rd(reg_addr));
            default: chk("R2 zero read", reg_rdata, 32'd0);
        endcase
    endtask

    task automatic put(input logic w, input logic [1:0] a, input logic [31:0] d,
                       input logic h, input logic ack);
        reg_wr = w; reg_addr = a; reg_wdata = d; halted = h; done_ack = ack;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all();
        // R1 reset state
        chk("R1 status", reg_rdata, 32'h0200_0000);
        chk("R1 valid", {31'd0, instr_valid}, 32'd0);
        put(0, 2'd2, '0, 0, 0);
        chk("R1 cache reg", reg_rdata, 32'd0);
        chk("R9 not halted", {29'd0, wt_n, if_n, df_n}, 32'd7);
        put(0, 2'd2, '0, 1, 0);
        chk("R1 restrictive", {29'd0, wt_n, if_n, df_n}, 32'd0);
        // R7 reserved bits ignored
        put(1, 2'd2, 32'hFFFF_FFFA, 1, 0);
        put(0, 2'd2, '0, 1, 0);
        chk("R7 readback", reg_rdata, 32'd2);
        chk("R8 follow", {29'd0, wt_n, if_n, df_n}, 32'd2);
        put(0, 2'd2, '0, 0, 0);
        chk("R9 override", {29'd0, wt_n, if_n, df_n}, 32'd7);
        // R3 gating
        put(1, 2'd1, 32'h1111_1111, 0, 0);
        chk("R3 not halted", {31'd0, instr_valid}, 32'd0);
        put(1, 2'd1, 32'h2222_2222, 1, 0);
        chk("R3 not enabled", {31'd0, instr_valid}, 32'd0);
        put(1, 2'd0, 32'h0000_2000, 1, 0);
        put(1, 2'd1, 32'h3333_3333, 0, 0);
        chk("R3 halt low enabled", {31'd0, instr_valid}, 32'd0);
        put(0, 2'd0, '0, 0, 0);
        chk("R3 no overrun", reg_rdata, 32'h0200_2000);
        // R4 accepted issue
        put(1, 2'd1, 32'hA5A5_1234, 1, 0);
        chk("R4 pulse", {31'd0, instr_valid}, 32'd1);
        chk("R4 word", instr_data, 32'hA5A5_1234);
        // R5 ack during pulse is ignored
        put(0, 2'd0, '0, 1, 1);
        chk("R5 ack ignored", reg_rdata, 32'h0000_2000);
        // R6 overrun
        put(1, 2'd1, 32'hDEAD_BEEF, 1, 0);
        chk("R6 dropped", {31'd0, instr_valid}, 32'd0);
        put(0, 2'd0, '0, 1, 0);
        chk("R6 set", reg_rdata, 32'h0000_2040);
        put(0, 2'd0, '0, 1, 1);
        chk("R5 done", reg_rdata, 32'h0200_2040);
        put(1, 2'd0, 32'h0000_2000, 1, 0);
        chk("R6 kept", reg_rdata, 32'h0200_2040);
        put(1, 2'd0, 32'h0000_2040, 1, 0);
        chk("R6 cleared", reg_rdata, 32'h0200_2000);
        put(1, 2'd1, 32'h0BAD_F00D, 1, 0);
        chk("R4 second", instr_data, 32'h0BAD_F00D);
        put(0, 2'd3, '0, 1, 1);
        chk("R2 addr3", reg_rdata, 32'd0);
        // Randomized phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            logic [1:0]  a;
            d = $urandom;
            a = 2'($urandom_range(0, 3));
            if (a == 2'd0 && $urandom_range(0, 3) != 0) d[13] = 1'b1;
            put(($urandom_range(0, 2) == 0), a, d,
                ($urandom_range(0, 5) != 0), ($urandom_range(0, 3) == 0));
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule